// File: doc/BRIEF.md
# Segmented-Source Word DMA Channel

This block is a general-purpose copy engine that sits on a 16-bit register bus and moves 16-bit words from anywhere in a 22-bit segmented address space into the low on-chip region that holds working RAM and peripheral registers. Software loads a source offset, a source segment and a destination address, then writes the number of words. That count write is the start command.

The engine moves one word at a time through a request/grant master port. It issues a read at the source, waits one cycle for the data, then issues a write at the destination. Both addresses step forward by one for every word, and the count steps down. Software polls the count register to follow progress: it shows the words still to move and reads zero when the copy is done. Writes to the registers are ignored while a copy is running.

Top module: `dma_word_engine`

## Requirements
- R1: After reset, all four registers read 0 and `mem_req` is low.
- R2: Register offsets are 0 = source offset (16 bits), 1 = source segment (6 bits, upper bits read 0), 2 = word count (16 bits), 3 = destination (14 bits, upper bits read 0). Reads return the stored value combinationally.
- R3: A non-zero write to the count register while idle starts a copy. In the next cycle `mem_req` is high with `mem_we` low and `mem_addr` = {segment, offset}.
- R4: A count write of 0 while idle starts nothing: no request is issued and the count reads 0.
- R5: Each word is one read at the source address, then a capture cycle with `mem_req` low in which `mem_rdata` (valid the cycle after the read grant) is taken, then one write at the destination carrying that data.
- R6: After each word the 22-bit source {segment, offset} increases by one. An offset carry moves into the segment, and the whole value wraps at 2^22. The registers read back the advanced value.
- R7: On writes `mem_addr` is the 14-bit destination with bits 21:14 zero. The destination increases by one per word, wrapping modulo 2^14.
- R8: The count drops by one at each granted write. Once it reaches 0 the engine stops requesting, and exactly the programmed number of words has been written.
- R9: While a copy runs, writes to any of the four registers are ignored.
- R10: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| mem_req | output | 1 | Master request |
| mem_gnt | input | 1 | Grant; a request completes in a cycle where both are high |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 22 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read grant |

## Verification
The bench builds the engine with its default widths: a 6-bit segment, a 14-bit destination and a 16-bit count. These values are narrow enough that copies starting at offset 0xFFFF with segment 0x3F, and at destination 0x3FFE, reach the offset-to-segment carry, the full 22-bit source wrap and the 14-bit destination wrap within a few words. Grant patterns of always-on, one-in-three-off and held-off exercise the stall hold and the live count.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_CAP,
        ST_WR
    } dma_state_e;

    localparam logic [1:0] REG_SRC = 2'd0;
    localparam logic [1:0] REG_SEG = 2'd1;
    localparam logic [1:0] REG_CNT = 2'd2;
    localparam logic [1:0] REG_TGT = 2'd3;
endpackage

// File: rtl/dma_incr.sv
module dma_incr #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    always_comb begin
        val_o = val_i + W'(1);
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    input  logic gnt_i,
    output logic busy_o,
    output logic req_o,
    output logic we_o,
    output logic cap_o,
    output logic done_o
);
    typedef struct packed {
        dma_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        req_o  = 1'b0;
        we_o   = 1'b0;
        cap_o  = 1'b0;
        done_o = 1'b0;
        busy_o = (seq_q.st != ST_IDLE);
        case (seq_q.st)
            ST_IDLE: if (start_i) seq_d.st = ST_RD;
            ST_RD: begin
                req_o = 1'b1;
                if (gnt_i) seq_d.st = ST_CAP;
            end
            ST_CAP: begin
                cap_o    = 1'b1;
                seq_d.st = ST_WR;
            end
            ST_WR: begin
                req_o = 1'b1;
                we_o  = 1'b1;
                if (gnt_i) begin
                    done_o   = 1'b1;
                    seq_d.st = last_i ? ST_IDLE : ST_RD;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE};
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/dma_word_engine.sv
module dma_word_engine
    import dma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 6,
    parameter int TGT_W  = 14,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [21:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    localparam int SRC_W = DATA_W + SEG_W;

    typedef struct packed {
        logic [SEG_W-1:0]  src_seg;
        logic [DATA_W-1:0] src_off;
        logic [CNT_W-1:0]  cnt;
        logic [TGT_W-1:0]  tgt;
        logic [DATA_W-1:0] hold;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             busy, cap, done, start, last, wr_ok;
    logic [SRC_W-1:0] src_cur, src_nxt;
    logic [TGT_W-1:0] tgt_cur, tgt_nxt;
    logic [CNT_W-1:0] cnt_cur;

    assign src_cur = {regs_q.src_seg, regs_q.src_off};
    assign tgt_cur = regs_q.tgt;
    assign cnt_cur = regs_q.cnt;
    assign wr_ok   = reg_we && !busy;
    assign start   = wr_ok && (reg_addr == REG_CNT) && (reg_wdata != '0);
    assign last    = (regs_q.cnt == CNT_W'(1));

    dma_incr #(.W(SRC_W)) u_src_inc (.val_i(src_cur), .val_o(src_nxt));
    dma_incr #(.W(TGT_W)) u_tgt_inc (.val_i(tgt_cur), .val_o(tgt_nxt));

    dma_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .last_i (last),
        .gnt_i  (mem_gnt),
        .busy_o (busy),
        .req_o  (mem_req),
        .we_o   (mem_we),
        .cap_o  (cap),
        .done_o (done)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) begin
            case (reg_addr)
                REG_SRC: regs_d.src_off = DATA_W'(reg_wdata);
                REG_SEG: regs_d.src_seg = SEG_W'(reg_wdata);
                REG_CNT: regs_d.cnt     = CNT_W'(reg_wdata);
                default: regs_d.tgt     = TGT_W'(reg_wdata);
            endcase
        end
        if (cap) regs_d.hold = DATA_W'(mem_rdata);
        if (done) begin
            {regs_d.src_seg, regs_d.src_off} = src_nxt;
            regs_d.tgt = tgt_nxt;
            regs_d.cnt = regs_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (reg_addr)
            REG_SRC: reg_rdata = 16'(regs_q.src_off);
            REG_SEG: reg_rdata = 16'(regs_q.src_seg);
            REG_CNT: reg_rdata = 16'(regs_q.cnt);
            default: reg_rdata = 16'(regs_q.tgt);
        endcase
    end

    assign mem_addr  = mem_we ? 22'(regs_q.tgt) : 22'(src_cur);
    assign mem_wdata = 16'(regs_q.hold);
endmodule

// File: rtl/dma_word_engine_chk.sv
module dma_word_engine_chk #(
    parameter int SRC_W = 22,
    parameter int TGT_W = 14,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_we,
    input logic [21:0]      mem_addr,
    input logic [15:0]      mem_wdata,
    input logic             busy,
    input logic [SRC_W-1:0] src_cur,
    input logic [TGT_W-1:0] tgt_cur,
    input logic [CNT_W-1:0] cnt_cur
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R10

    AST_WR_LOW_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[21:14] == 8'd0); // R7

    AST_RD_CAP_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_gnt |=> !mem_req ##1 (mem_req && mem_we)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_gnt |=> cnt_cur == $past(cnt_cur) - CNT_W'(1)); // R8

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_gnt |=> src_cur == $past(src_cur) + SRC_W'(1)); // R6

    AST_ZERO_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cur == '0 |-> !mem_req); // R4

    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(mem_req && mem_we && mem_gnt) |=> $stable(src_cur) && $stable(tgt_cur) && $stable(cnt_cur)); // R9
endmodule

bind dma_word_engine dma_word_engine_chk #(
    .SRC_W(SRC_W),
    .TGT_W(TGT_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .src_cur  (src_cur),
    .tgt_cur  (tgt_cur),
    .cnt_cur  (cnt_cur)
);

// File: tb/tb_dma_word_engine.sv
`timescale 1ns/1ps
module tb_dma_word_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic        mem_we;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'd0;

    int n_chk = 0;
    int n_fail = 0;
    int gnt_mode = 0;
    int tick = 0;
    int log_n = 0;
    logic [21:0] log_addr [256];
    logic [15:0] log_data [256];

    always #2.5 clk = ~clk;

    dma_word_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] src_word(input logic [21:0] a);
        return a[15:0] ^ {a[21:16], 10'h155};
    endfunction

    always @(negedge clk) begin
        tick <= tick + 1;
        case (gnt_mode)
            0:       mem_gnt <= 1'b1;
            1:       mem_gnt <= (tick % 3) != 0;
            default: mem_gnt <= 1'b0;
        endcase
    end

    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                if (log_n < 256) begin
                    log_addr[log_n] <= mem_addr;
                    log_data[log_n] <= mem_wdata;
                end
                log_n <= log_n + 1;
            end else begin
                mem_rdata <= src_word(mem_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [15:0] c;
        for (int g = 0; g < 5000; g++) begin
            rd(2'd2, c);
            if (c == 16'd0) break;
        end
    endtask

    typedef struct packed {
        logic [15:0] off;
        logic [5:0]  seg;
        logic [13:0] tgt;
        logic [15:0] cnt;
        logic [1:0]  mode;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{off: 16'h1000, seg: 6'h00, tgt: 14'h0100, cnt: 16'd3, mode: 2'd0},
        '{off: 16'hFFFE, seg: 6'h02, tgt: 14'h0200, cnt: 16'd4, mode: 2'd1},
        '{off: 16'hFFFF, seg: 6'h3F, tgt: 14'h3FFE, cnt: 16'd4, mode: 2'd0},
        '{off: 16'h4321, seg: 6'h05, tgt: 14'h2ABC, cnt: 16'd1, mode: 2'd1},
        '{off: 16'h0000, seg: 6'h01, tgt: 14'h0000, cnt: 16'd7, mode: 2'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [21:0] s0, es;
        logic [13:0] et;
        int base;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            chk(v == 16'd0, "R1", 32'(v), 32'd0);
        end
        chk(mem_req == 1'b0, "R1", 32'(mem_req), 32'd0);

        // R2: widths and readback
        wr(2'd0, 16'hBEEF);
        wr(2'd1, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        rd(2'd0, v); chk(v == 16'hBEEF, "R2", 32'(v), 32'hBEEF);
        rd(2'd1, v); chk(v == 16'h003F, "R2", 32'(v), 32'h3F);
        rd(2'd3, v); chk(v == 16'h3FFF, "R2", 32'(v), 32'h3FFF);

        // R4: zero count starts nothing
        base = log_n;
        wr(2'd2, 16'd0);
        repeat (4) @(negedge clk);
        chk(mem_req == 1'b0, "R4", 32'(mem_req), 32'd0);
        chk(log_n == base, "R4", 32'(log_n), 32'(base));
        rd(2'd2, v); chk(v == 16'd0, "R4", 32'(v), 32'd0);

        // R5 R6 R7 R8: vector table
        for (int k = 0; k < 5; k++) begin
            gnt_mode = int'(VECS[k].mode);
            wr(2'd0, VECS[k].off);
            wr(2'd1, 16'(VECS[k].seg));
            wr(2'd3, 16'(VECS[k].tgt));
            base = log_n;
            wr(2'd2, VECS[k].cnt);
            wait_done();
            chk(log_n - base == int'(VECS[k].cnt), "R8", 32'(log_n - base), 32'(VECS[k].cnt));
            chk(mem_req == 1'b0, "R8", 32'(mem_req), 32'd0);
            s0 = {VECS[k].seg, VECS[k].off};
            for (int i = 0; i < int'(VECS[k].cnt); i++) begin
                es = s0 + 22'(i);
                et = VECS[k].tgt + 14'(i);
                chk(log_addr[base + i] == 22'(et), "R7", 32'(log_addr[base + i]), 32'(et));
                chk(log_data[base + i] == src_word(es), "R5", 32'(log_data[base + i]), 32'(src_word(es)));
            end
            es = s0 + 22'(VECS[k].cnt);
            et = VECS[k].tgt + 14'(VECS[k].cnt);
            rd(2'd0, v); chk(v == es[15:0], "R6", 32'(v), 32'(es[15:0]));
            rd(2'd1, v); chk(v == 16'(es[21:16]), "R6", 32'(v), 32'(es[21:16]));
            rd(2'd3, v); chk(v == 16'(et), "R7", 32'(v), 32'(et));
        end

        // R3 R10 R9: start, stall hold, writes locked while busy
        gnt_mode = 2;
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h0123);
        wr(2'd1, 16'h0004);
        wr(2'd3, 16'h0040);
        base = log_n;
        wr(2'd2, 16'd3);
        chk(mem_req == 1'b1 && mem_we == 1'b0, "R3", {mem_req, mem_we}, 32'h2);
        chk(mem_addr == 22'h040123, "R3", 32'(mem_addr), 32'h040123);
        repeat (4) @(negedge clk);
        #1;
        chk(mem_req == 1'b1 && mem_addr == 22'h040123, "R10", 32'(mem_addr), 32'h040123);
        wr(2'd0, 16'hAAAA);
        wr(2'd1, 16'h0007);
        wr(2'd3, 16'h1111);
        wr(2'd2, 16'd9);
        rd(2'd0, v); chk(v == 16'h0123, "R9", 32'(v), 32'h0123);
        rd(2'd1, v); chk(v == 16'h0004, "R9", 32'(v), 32'h4);
        rd(2'd3, v); chk(v == 16'h0040, "R9", 32'(v), 32'h40);
        rd(2'd2, v); chk(v == 16'd3, "R8", 32'(v), 32'd3);
        gnt_mode = 0;
        wait_done();
        chk(log_n - base == 3, "R9", 32'(log_n - base), 32'd3);
        for (int i = 0; i < 3; i++) begin
            es = 22'h040123 + 22'(i);
            chk(log_addr[base + i] == 22'h40 + 22'(i), "R9", 32'(log_addr[base + i]), 32'h40 + 32'(i));
            chk(log_data[base + i] == src_word(es), "R5", 32'(log_data[base + i]), 32'(src_word(es)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule